// File: doc/BRIEF.md
# Descriptor-Chain Memory-to-Stream Engine

This block walks a linked list of transfer descriptors held in memory and turns each described buffer into a byte stream. It reads the descriptor at the current pointer over a simple word-wide memory master port. It then reads the buffer the descriptor names, emits the bytes on a valid/ready byte stream, writes a completion status back into the descriptor and follows the next pointer. Descriptors flagged as the start of a frame also send a set of five application words on a separate valid/ready sideband before their data. Several descriptors can make up one frame: only the one flagged as the end of a frame closes the packet on the stream and raises a completion pulse.

The surrounding register block supplies a run level, a current pointer load and a tail pointer write. Writing the tail pointer arms the engine. The engine stops and reports idle after it has processed the descriptor at the tail address. It stops and reports halted if it fetches a descriptor whose completed bit is already set, which means software has not recycled that descriptor. The memory port completes an access in the cycle where request and ready are both high; read data is taken in that same cycle.

Top module: `sgw_walker`

## Requirements
- R1: Out of reset the engine is halted (`sts_halted`=1), not idle (`sts_idle`=0), `cur_ptr` is 0, and `mem_req`, `st_valid` and `sb_valid` are low.
- R2: A descriptor fetch begins only while `cfg_run`=1, `sts_idle`=0 and `sts_halted`=0; a tail pointer write clears both `sts_idle` and `sts_halted`; with `cfg_run`=0 no memory access is made.
- R3: A descriptor is eight header words read from byte offsets 0 to 28 of `cur_ptr`: next pointer at +0, buffer address at +8, control at +24 (bits 22:0 length in bytes, bit 27 start of frame, bit 26 end of frame, other bits ignored), status at +28.
- R4: If the fetched status word has bit 31 set, the engine sets `sts_halted`, moves no data, writes nothing back and leaves `cur_ptr` unchanged.
- R5: For a start-of-frame descriptor, the five words at offsets +32 to +48 go out on the sideband in address order before any data byte, with `sb_last` only on the fifth.
- R6: Exactly length bytes are read from the word-aligned buffer and sent lowest byte lane first; `st_last` is high only on the final byte of an end-of-frame descriptor.
- R7: While `st_valid`=1 and `st_ready`=0 the byte and last flag hold, and no memory request is made while a byte is pending on the stream; the sideband holds likewise.
- R8: After the data, the status word at +28 is written with the length ORed with bit 31; a zero-length descriptor moves no data but is still written back and advanced.
- R9: `evt_done` pulses, coinciding with the accepted status write, only for descriptors carrying the end-of-frame bit.
- R10: After the write-back `cur_ptr` takes the next pointer; if the processed descriptor was at the tail address `sts_idle` is set and the engine stops, otherwise it fetches the next descriptor; a later tail write resumes from `cur_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Run level; low blocks new descriptor fetches |
| cfg_cur_wr | input | 1 | Load `cfg_cur_ptr` into the current pointer (acts while stopped) |
| cfg_cur_ptr | input | AW | Current pointer load value |
| cfg_tail_wr | input | 1 | Tail pointer write strobe; clears idle and halted |
| cfg_tail_ptr | input | AW | Tail pointer value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid when the read completes |
| st_valid | output | 1 | Stream byte valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of a frame |
| sb_valid | output | 1 | Sideband word valid |
| sb_ready | input | 1 | Sideband sink ready |
| sb_data | output | 32 | Application word |
| sb_last | output | 1 | Fifth application word |
| sts_idle | output | 1 | Stopped after reaching the tail |
| sts_halted | output | 1 | Stopped on reset or on an already completed descriptor |
| cur_ptr | output | AW | Current descriptor pointer |
| evt_done | output | 1 | End-of-frame descriptor completed |

## Verification
Chains are tried as a single descriptor that is both start and end of frame, as a three-descriptor frame with a zero-length middle piece, and as a long buffer whose length is not a multiple of four with junk in the unused control bits. Together these separate correct frame assembly (application words once, last flag once) from per-descriptor framing, and exact byte counts from whole-word counts. Ready patterns switch between always-ready and pseudo-random stalls on memory, stream and sideband to expose lost or repeated bytes under backpressure. A stale descriptor, a run-low arm and a tail extension after idle tell apart the three ways the engine stops or resumes.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;
  localparam int WORD_BYTES    = 4;
  localparam int HDR_WORDS     = 8;
  localparam int W_NEXT        = 0;
  localparam int W_BUF         = 2;
  localparam int W_CTRL        = 6;
  localparam int W_STAT        = 7;
  localparam int APP_FIRST     = 8;
  localparam int BIT_FRAME_BEG = 27;
  localparam int BIT_FRAME_END = 26;
  localparam int BIT_COMPLETED = 31;

  typedef enum logic [2:0] {
    ST_WAIT, ST_HDR, ST_CHK, ST_APP, ST_DATA, ST_DRAIN, ST_WB, ST_ADV
  } walk_st_e;

  // status written back: byte count with the completed flag
  function automatic logic [31:0] status_word(input logic [31:0] nbytes);
    status_word = nbytes | (32'd1 << BIT_COMPLETED);
  endfunction

  // bytes carried by the next buffer word
  function automatic logic [2:0] chunk_bytes(input logic [31:0] remain);
    chunk_bytes = (remain >= 32'(WORD_BYTES)) ? 3'(WORD_BYTES) : remain[2:0];
  endfunction
endpackage

// File: rtl/sgw_ptr_regs.sv
`timescale 1ns/1ps
module sgw_ptr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_cur,
  input  logic [AW-1:0] ld_cur_val,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_val,
  input  logic          adv,
  input  logic [AW-1:0] adv_next,
  input  logic          set_halt,
  output logic [AW-1:0] cur,
  output logic          idle,
  output logic          halted
);
  logic [AW-1:0] tail_q;
  logic          at_tail;

  assign at_tail = (cur == tail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      tail_q <= '0;
      idle   <= 1'b0;
      halted <= 1'b1;
    end else begin
      if (ld_cur) cur <= ld_cur_val;
      if (adv)    cur <= adv_next;
      if (tail_wr) tail_q <= tail_val;
      if (set_halt) halted <= 1'b1;
      if (adv && at_tail) idle <= 1'b1;
      if (tail_wr) begin
        idle   <= 1'b0;
        halted <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sgw_unpack.sv
`timescale 1ns/1ps
module sgw_unpack #(
  parameter int BPW = 4,
  localparam int CW = $clog2(BPW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [8*BPW-1:0] load_word,
  input  logic [CW-1:0]  load_cnt,
  input  logic           load_last,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_last,
  output logic           empty
);
  logic [8*BPW-1:0] word_q;
  logic [CW-1:0]    cnt_q;
  logic             last_q;

  assign empty     = (cnt_q == '0);
  assign out_valid = !empty;
  assign out_data  = word_q[7:0];
  assign out_last  = last_q && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      cnt_q  <= load_cnt;
      last_q <= load_last;
    end else if (out_valid && out_ready) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/sgw_slot.sv
`timescale 1ns/1ps
module sgw_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         din_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
      out_last  <= din_last;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sgw_walker.sv
`timescale 1ns/1ps
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 23,
  parameter int APP_N = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_run,
  input  logic          cfg_cur_wr,
  input  logic [AW-1:0] cfg_cur_ptr,
  input  logic          cfg_tail_wr,
  input  logic [AW-1:0] cfg_tail_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [7:0]    st_data,
  output logic          st_last,
  output logic          sb_valid,
  input  logic          sb_ready,
  output logic [31:0]   sb_data,
  output logic          sb_last,
  output logic          sts_idle,
  output logic          sts_halted,
  output logic [AW-1:0] cur_ptr,
  output logic          evt_done
);
  localparam int IW  = $clog2(APP_FIRST + APP_N);
  localparam int BPW = WORD_BYTES;
  localparam int CW  = $clog2(BPW + 1);

  walk_st_e         state;
  logic [IW-1:0]    idx_q;
  logic [AW-1:0]    nxt_q, buf_q, baddr_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic             sof_q, eof_q, stale_q;

  // named internal events
  logic mem_acc, go, ev_hdr_acc, ev_stale, ev_app_load, ev_app_take;
  logic ev_beat_acc, ev_wb_acc, ev_adv, ld_cur;
  logic un_empty;
  logic [2:0] chunk;
  logic [IW+1:0] hdr_off, app_off;

  assign mem_acc     = mem_req && mem_ready;
  assign go          = cfg_run && !sts_idle && !sts_halted;
  assign ev_hdr_acc  = (state == ST_HDR) && mem_acc;
  assign ev_stale    = (state == ST_CHK) && stale_q;
  assign ev_app_load = (state == ST_APP) && mem_acc;
  assign ev_app_take = (state == ST_APP) && sb_valid && sb_ready;
  assign ev_beat_acc = (state == ST_DATA) && mem_acc;
  assign ev_wb_acc   = (state == ST_WB) && mem_acc;
  assign ev_adv      = (state == ST_ADV);
  assign evt_done    = ev_wb_acc && eof_q;
  assign ld_cur      = cfg_cur_wr && (state == ST_WAIT);
  assign chunk       = chunk_bytes(32'(rem_q));
  assign hdr_off     = {idx_q, 2'b00};
  assign app_off     = {idx_q + IW'(APP_FIRST), 2'b00};

  // memory master
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    unique case (state)
      ST_HDR: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + AW'(hdr_off);
      end
      ST_APP: begin
        mem_req  = !sb_valid;
        mem_addr = cur_ptr + AW'(app_off);
      end
      ST_DATA: begin
        mem_req  = un_empty && (rem_q != '0);
        mem_addr = baddr_q;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + AW'(W_STAT * WORD_BYTES);
        mem_wdata = status_word(32'(len_q));
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      idx_q   <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      stale_q <= 1'b0;
      rem_q   <= '0;
      baddr_q <= '0;
    end else begin
      unique case (state)
        ST_WAIT: if (go) begin
          state <= ST_HDR;
          idx_q <= '0;
        end
        ST_HDR: if (ev_hdr_acc) begin
          if (idx_q == IW'(W_NEXT)) nxt_q <= mem_rdata[AW-1:0];
          if (idx_q == IW'(W_BUF))  buf_q <= mem_rdata[AW-1:0];
          if (idx_q == IW'(W_CTRL)) begin
            len_q <= mem_rdata[LEN_W-1:0];
            sof_q <= mem_rdata[BIT_FRAME_BEG];
            eof_q <= mem_rdata[BIT_FRAME_END];
          end
          if (idx_q == IW'(W_STAT)) stale_q <= mem_rdata[BIT_COMPLETED];
          if (idx_q == IW'(HDR_WORDS - 1)) state <= ST_CHK;
          else idx_q <= idx_q + IW'(1);
        end
        ST_CHK: begin
          if (stale_q) begin
            state <= ST_WAIT;
          end else begin
            rem_q   <= len_q;
            baddr_q <= buf_q;
            idx_q   <= '0;
            state   <= sof_q ? ST_APP : ST_DATA;
          end
        end
        ST_APP: if (ev_app_take) begin
          if (idx_q == IW'(APP_N - 1)) state <= ST_DATA;
          else idx_q <= idx_q + IW'(1);
        end
        ST_DATA: begin
          if (rem_q == '0) begin
            state <= ST_DRAIN;
          end else if (ev_beat_acc) begin
            rem_q   <= rem_q - LEN_W'(chunk);
            baddr_q <= baddr_q + AW'(BPW);
          end
        end
        ST_DRAIN: if (un_empty) state <= ST_WB;
        ST_WB:    if (ev_wb_acc) state <= ST_ADV;
        ST_ADV:   state <= ST_WAIT;
        default:  state <= ST_WAIT;
      endcase
    end
  end

  sgw_ptr_regs #(.AW(AW)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_cur     (ld_cur),
    .ld_cur_val (cfg_cur_ptr),
    .tail_wr    (cfg_tail_wr),
    .tail_val   (cfg_tail_ptr),
    .adv        (ev_adv),
    .adv_next   (nxt_q),
    .set_halt   (ev_stale),
    .cur        (cur_ptr),
    .idle       (sts_idle),
    .halted     (sts_halted)
  );

  sgw_unpack #(.BPW(BPW)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_beat_acc),
    .load_word (mem_rdata),
    .load_cnt  (CW'(chunk)),
    .load_last (eof_q && (rem_q <= LEN_W'(BPW))),
    .out_valid (st_valid),
    .out_ready (st_ready),
    .out_data  (st_data),
    .out_last  (st_last),
    .empty     (un_empty)
  );

  sgw_slot #(.W(32)) u_app (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_app_load),
    .din       (mem_rdata),
    .din_last  (idx_q == IW'(APP_N - 1)),
    .out_valid (sb_valid),
    .out_ready (sb_ready),
    .out_data  (sb_data),
    .out_last  (sb_last)
  );
endmodule

// File: rtl/sgw_walker_chk.sv
`timescale 1ns/1ps
module sgw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        st_valid,
  input logic        st_ready,
  input logic [7:0]  st_data,
  input logic        st_last,
  input logic        sb_valid,
  input logic        sb_ready,
  input logic [31:0] sb_data,
  input logic        sb_last,
  input logic        sts_idle,
  input logic        sts_halted,
  input logic        evt_done,
  input logic        cfg_tail_wr,
  input logic        ev_stale,
  input logic        ev_adv
);
  a_r7_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));

  a_r7_sideband_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid && !sb_ready |=> sb_valid && $stable(sb_data) && $stable(sb_last));

  a_r7_no_read_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !mem_req);

  a_r8_wb_completed_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[31]);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sts_idle |-> !mem_req);

  a_r2_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sts_halted |-> !mem_req);

  a_r9_done_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> mem_req && mem_we && mem_ready);

  a_r4_stale_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stale && !cfg_tail_wr |=> sts_halted);

  a_r10_idle_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_idle) |-> $past(ev_adv));
endmodule

bind sgw_walker sgw_walker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata),
  .mem_ready   (mem_ready),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .st_data     (st_data),
  .st_last     (st_last),
  .sb_valid    (sb_valid),
  .sb_ready    (sb_ready),
  .sb_data     (sb_data),
  .sb_last     (sb_last),
  .sts_idle    (sts_idle),
  .sts_halted  (sts_halted),
  .evt_done    (evt_done),
  .cfg_tail_wr (cfg_tail_wr),
  .ev_stale    (ev_stale),
  .ev_adv      (ev_adv)
);

// File: tb/sgw_walker_tb.sv
`timescale 1ns/1ps
module sgw_walker_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_run, cfg_cur_wr, cfg_tail_wr;
  logic [31:0] cfg_cur_ptr, cfg_tail_ptr;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        st_valid, st_ready, st_last;
  logic [7:0]  st_data;
  logic        sb_valid, sb_ready, sb_last;
  logic [31:0] sb_data;
  logic        sts_idle, sts_halted, evt_done;
  logic [31:0] cur_ptr;

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[11:2]];

  sgw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run),
    .cfg_cur_wr(cfg_cur_wr), .cfg_cur_ptr(cfg_cur_ptr),
    .cfg_tail_wr(cfg_tail_wr), .cfg_tail_ptr(cfg_tail_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last),
    .sb_valid(sb_valid), .sb_ready(sb_ready), .sb_data(sb_data), .sb_last(sb_last),
    .sts_idle(sts_idle), .sts_halted(sts_halted), .cur_ptr(cur_ptr),
    .evt_done(evt_done)
  );

  int nchk = 0, nbad = 0;
  int exp_done = 0, done_seen = 0, req_seen = 0;
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0]  exp_st[$];
  logic [32:0] exp_sb[$];
  logic [63:0] exp_wb[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  // descriptor builder: memory image plus expected traffic
  task automatic put_desc(input int d, input int nxt, input int bufa, input int len,
                          input bit sof, input bit eof, input bit stale,
                          input logic [31:0] junk);
    int w = d >> 2;
    mem[w+0] = 32'(nxt);  mem[w+1] = 32'h0;
    mem[w+2] = 32'(bufa); mem[w+3] = 32'h0;
    mem[w+4] = 32'hDEAD_0004; mem[w+5] = 32'hDEAD_0005;
    mem[w+6] = 32'(len) | (32'(sof) << 27) | (32'(eof) << 26) | junk;
    mem[w+7] = stale ? 32'h8000_0055 : 32'h0000_0000;
    for (int k = 0; k < 5; k++) mem[w+8+k] = 32'hA000_0000 | (32'(d) << 8) | 32'(k);
    for (int b = 0; b < len; b++)
      mem[(bufa >> 2) + (b >> 2)][8*(b & 3) +: 8] = 8'(d + 3*b + 7);
    if (!stale) begin
      if (sof)
        for (int k = 0; k < 5; k++)
          exp_sb.push_back({k == 4, 32'hA000_0000 | (32'(d) << 8) | 32'(k)});
      for (int b = 0; b < len; b++)
        exp_st.push_back({eof && (b == len - 1), 8'(d + 3*b + 7)});
      exp_wb.push_back({32'(d + 28), 32'(len) | 32'h8000_0000});
      if (eof) exp_done++;
    end
  endtask

  task automatic set_cur(input int a);
    @(negedge clk); cfg_cur_ptr = 32'(a); cfg_cur_wr = 1'b1;
    @(negedge clk); cfg_cur_wr = 1'b0;
  endtask

  task automatic kick_tail(input int a);
    @(negedge clk); cfg_tail_ptr = 32'(a); cfg_tail_wr = 1'b1;
    @(negedge clk); cfg_tail_wr = 1'b0;
  endtask

  task automatic wait_stop();
    int t = 0;
    repeat (2) @(negedge clk);
    while (!(sts_idle || sts_halted) && t < 5000) begin
      @(negedge clk); t++;
    end
    if (t >= 5000) chk("R10 engine stops", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic end_check(input string tag);
    chk({tag, " R6 all bytes seen"}, 64'(exp_st.size()), 0);
    chk({tag, " R5 all app words seen"}, 64'(exp_sb.size()), 0);
    chk({tag, " R8 all write-backs seen"}, 64'(exp_wb.size()), 0);
    chk({tag, " R9 done count"}, 64'(done_seen), 64'(exp_done));
  endtask

  // per-clock driver and monitor: drive at negedge, sample 1 ns later
  initial begin : mon
    logic       hold_st, hold_sb;
    logic [8:0] prev_st;
    logic [32:0] prev_sb;
    hold_st = 0; hold_sb = 0; prev_st = '0; prev_sb = '0;
    mem_ready = 1'b1; st_ready = 1'b1; sb_ready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = stall_mode ? (lfsr[0] | lfsr[4]) : 1'b1;
      st_ready  = stall_mode ? lfsr[3] : 1'b1;
      sb_ready  = stall_mode ? (lfsr[7] & lfsr[9]) : 1'b1;
      #1;
      if (rst_n) begin
        if (hold_st) chk("R7 stream holds", {st_valid, st_last, st_data}, {1'b1, prev_st});
        if (hold_sb) chk("R7 sideband holds", {sb_valid, sb_last, sb_data}, {1'b1, prev_sb});
        if (st_valid) chk("R7 no request while byte pending", 64'(mem_req), 0);
        if (mem_req) req_seen++;
        if (evt_done) done_seen++;
        if (st_valid && st_ready) begin
          chk("R5 app words precede data", 64'(exp_sb.size()), 0);
          if (exp_st.size() == 0) chk("R6 unexpected byte", {st_last, st_data}, 9'h1FF);
          else chk("R6 byte and last", {st_last, st_data}, exp_st.pop_front());
        end
        if (sb_valid && sb_ready) begin
          if (exp_sb.size() == 0) chk("R5 unexpected app word", {sb_last, sb_data}, '1);
          else chk("R5 app word", {sb_last, sb_data}, exp_sb.pop_front());
        end
        if (mem_req && mem_we && mem_ready) begin
          if (exp_wb.size() == 0) chk("R8 unexpected write-back", {mem_addr, mem_wdata}, '1);
          else chk("R8 write-back addr and data", {mem_addr, mem_wdata}, exp_wb.pop_front());
        end
        hold_st = st_valid && !st_ready; prev_st = {st_last, st_data};
        hold_sb = sb_valid && !sb_ready; prev_sb = {sb_last, sb_data};
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=running exp=finished");
    report();
    $finish;
  end

  initial begin : main
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    rst_n = 0; cfg_run = 0; cfg_cur_wr = 0; cfg_tail_wr = 0;
    cfg_cur_ptr = '0; cfg_tail_ptr = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 halted", 64'(sts_halted), 1);
    chk("R1 idle", 64'(sts_idle), 0);
    chk("R1 cur_ptr", 64'(cur_ptr), 0);
    chk("R1 mem_req", 64'(mem_req), 0);
    chk("R1 stream/sideband valid", {st_valid, sb_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R2 no fetch before tail write", 64'(req_seen), 0);

    // T1: one descriptor, start and end of frame (R3 R5 R6 R8 R9 R10)
    put_desc(32'h100, 32'h140, 32'h800, 6, 1, 1, 0, 32'h0);
    set_cur(32'h100);
    cfg_run = 1;
    kick_tail(32'h100);
    wait_stop();
    chk("R10 idle at tail", {sts_idle, sts_halted}, 2'b10);
    chk("R10 cur follows next", 64'(cur_ptr), 64'h140);
    end_check("T1");

    // T2: three-piece frame with zero-length middle, random stalls (R6 R7 R8)
    stall_mode = 1;
    put_desc(32'h140, 32'h180, 32'h840, 5, 1, 0, 0, 32'h0);
    put_desc(32'h180, 32'h1C0, 32'h880, 0, 0, 0, 0, 32'h0);
    put_desc(32'h1C0, 32'h200, 32'h8C0, 7, 0, 1, 0, 32'h0);
    kick_tail(32'h1C0);
    wait_stop();
    chk("R10 stops at tail of chain", 64'(cur_ptr), 64'h200);
    end_check("T2");
    // tail extension resumes from cur_ptr (R10)
    put_desc(32'h200, 32'h240, 32'h900, 9, 1, 1, 0, 32'h0);
    kick_tail(32'h200);
    wait_stop();
    chk("R10 resumed chain idle", {sts_idle, 64'(cur_ptr)}, {1'b1, 64'h240});
    end_check("T2b");

    // T3: stale descriptor halts (R4)
    put_desc(32'h240, 32'h280, 32'h940, 4, 1, 1, 1, 32'h0);
    kick_tail(32'h240);
    wait_stop();
    chk("R4 halted on completed bit", {sts_halted, sts_idle}, 2'b10);
    chk("R4 cur_ptr unchanged", 64'(cur_ptr), 64'h240);
    end_check("T3");

    // T4: run low blocks fetch (R2)
    put_desc(32'h240, 32'h280, 32'h940, 4, 1, 1, 0, 32'h0);
    cfg_run = 0;
    r0 = req_seen;
    kick_tail(32'h240);
    repeat (30) @(negedge clk);
    chk("R2 no access while run low", 64'(req_seen), 64'(r0));
    chk("R2 tail write cleared flags", {sts_idle, sts_halted}, 2'b00);
    cfg_run = 1;
    wait_stop();
    chk("R2 run high starts chain", {sts_idle, 64'(cur_ptr)}, {1'b1, 64'h280});
    end_check("T4");

    // T5: long odd length, junk control bits ignored (R3 R6 R7)
    put_desc(32'h300, 32'h340, 32'hA00, 33, 1, 1, 0, 32'h0080_0000 | 32'h3000_0000);
    set_cur(32'h300);
    kick_tail(32'h300);
    wait_stop();
    chk("R3 length masked, idle", {sts_idle, 64'(cur_ptr)}, {1'b1, 64'h340});
    end_check("T5");

    // T6: no stalls, two frames back to back without SOF on second piece
    stall_mode = 0;
    put_desc(32'h340, 32'h380, 32'hA80, 3, 1, 1, 0, 32'h0);
    put_desc(32'h380, 32'h3C0, 32'hAC0, 4, 0, 1, 0, 32'h0);
    kick_tail(32'h380);
    wait_stop();
    chk("R10 two descriptors walked", 64'(cur_ptr), 64'h3C0);
    end_check("T6");

    report();
    $finish;
  end
endmodule